// File: doc/BRIEF.md
# Fixed-Address I2C Special Command Decoder

This block is an I2C slave that listens on one hardwired 7-bit address, independent of any firmware setting. A bus master writes a single command byte to that address. One code arms a sticky bootload-enable flag. A second code asks the chip to reset itself. Any other code clears the flag. A recognised command is held as pending and only acts when the STOP condition that closes the transfer is seen.

The bus pins are sampled on the system clock through a synchronizer. The block pulls SDA low only through an output-enable, to acknowledge bytes, and never drives SCL. The flag is cleared only by a power-on reset input, so it survives the chip reset that the block itself requests. A port-enable input switches the whole responder off.

Top module: `i2c_fixed_cmd_slave`

## Requirements
- R1: A write header to the fixed address (byte 68h: address 34h with R/W bit 0, sent MSB first) is ACKed. The slave drives SDA low for the whole ninth SCL high phase.
- R2: Any other address, and a read header to 34h (byte 69h), are not ACKed. SDA is never driven for the rest of that transfer, and a command byte that follows has no effect.
- R3: Data byte F0h, followed by STOP, sets `boot_en` to 1. `boot_en` does not change before the STOP.
- R4: Data byte BBh, followed by STOP, raises `reset_req` for exactly one clock cycle after the STOP. No pulse appears before the STOP.
- R5: Any data byte other than F0h or BBh is NACKed and clears `boot_en` to 0 without waiting for STOP.
- R6: `boot_en` is 0 after `por`. It keeps its value through `rst`. `reset_req` and `sda_oe` are 0 after either reset.
- R7: While `port_en` is 0, no byte is ACKed and no command acts.
- R8: A repeated START after an ACKed command byte drops that command. A later STOP then has no effect.
- R9: The two recognised command bytes F0h and BBh are ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high (does not touch the flag) |
| por | input | 1 | Synchronous power-on reset, active high (clears everything) |
| port_en | input | 1 | Enables the responder when 1 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| boot_en | output | 1 | Sticky bootload-enable flag |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
Two situations are the hardest to reach from the ports. The first is a command that has been accepted and ACKed but whose transfer never ends in its own STOP. The bench creates it by sending a repeated START right after the ACKed command byte. It then addresses a foreign slave and closes with STOP, and checks that neither the flag nor the reset pulse moves. The second is the split between the two resets. The flag is set over the bus, then `rst` is pulsed, and the flag must stay at 1 until `por` is pulsed.

// File: rtl/i2ccmd_pkg.sv
package i2ccmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_BOOT,
        CMD_RESET,
        CMD_BAD
    } cmd_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic cmd_e decode_cmd(input logic [7:0] code,
                                        input logic [7:0] boot_code,
                                        input logic [7:0] reset_code);
        if (code == boot_code)       return CMD_BOOT;
        else if (code == reset_code) return CMD_RESET;
        else                         return CMD_BAD;
    endfunction

    function automatic logic write_hit(input logic [7:0] hdr, input logic [6:0] addr);
        return hdr == {addr, 1'b0};
    endfunction

endpackage

// File: rtl/i2ccmd_sync.sv
module i2ccmd_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], din[g]};
        end
        assign dout[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/i2ccmd_cond.sv
module i2ccmd_cond
    import i2ccmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
        evt.rise  = scl_s & ~scl_d;
        evt.fall  = ~scl_s & scl_d;
        evt.sda   = sda_s;
    end
endmodule

// File: rtl/i2ccmd_fsm.sv
module i2ccmd_fsm
    import i2ccmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h34,
    parameter logic [7:0] BOOT_CODE  = 8'hF0,
    parameter logic [7:0] RESET_CODE = 8'hBB
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     port_en,
    input  bus_evt_t evt,
    output logic     sda_oe,
    output cmd_e     fire,
    output logic     bad
);
    localparam int          CNT_W = 4;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(8);

    bus_state_e       state;
    cmd_e             pend;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] cnt;
    cmd_e             code_kind;

    assign code_kind = decode_cmd(shreg, BOOT_CODE, RESET_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend   <= CMD_NONE;
            shreg  <= '0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            fire   <= CMD_NONE;
            bad    <= 1'b0;
        end else begin
            fire <= CMD_NONE;
            bad  <= 1'b0;
            if (!port_en) begin
                state  <= ST_IDLE;
                pend   <= CMD_NONE;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                fire   <= pend;
                pend   <= CMD_NONE;
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                pend   <= CMD_NONE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (evt.rise && cnt != FULL) begin
                            shreg <= {shreg[6:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (write_hit(shreg, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else if (code_kind == CMD_BAD) begin
                                bad   <= 1'b1;
                                state <= ST_IGNORE;
                            end else begin
                                pend   <= code_kind;
                                sda_oe <= 1'b1;
                                state  <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: no drive while idle or ignoring a foreign transfer
    p_quiet_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

    // R7: disabling the port returns to idle with SDA released
    p_port_off_r7: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (state == ST_IDLE && !sda_oe && fire == CMD_NONE));

    // R8: a START with no STOP leaves nothing pending
    p_start_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (port_en && evt.start && !evt.stop) |=> pend == CMD_NONE);

    // R1: drive begins only right after a falling SCL
    p_ack_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(evt.fall));
endmodule

// File: rtl/i2ccmd_flag.sv
module i2ccmd_flag
    import i2ccmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  cmd_e fire,
    input  logic bad,
    output logic boot_en,
    output logic reset_req
);
    always_ff @(posedge clk) begin
        if (por)                    boot_en <= 1'b0;
        else if (fire == CMD_BOOT)  boot_en <= 1'b1;
        else if (bad)               boot_en <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || por) reset_req <= 1'b0;
        else            reset_req <= (fire == CMD_RESET);
    end

    // R4: reset request is a single-cycle pulse
    p_pulse_one_r4: assert property (@(posedge clk) disable iff (rst || por)
        reset_req |=> !reset_req);

    // R3: the flag rises only from a command released at STOP
    p_set_at_stop_r3: assert property (@(posedge clk) disable iff (por)
        $rose(boot_en) |-> $past(fire == CMD_BOOT));

    // R6: system reset alone leaves the flag untouched
    p_survive_r6: assert property (@(posedge clk) disable iff (por)
        (rst && fire == CMD_NONE && !bad) |=> $stable(boot_en));
endmodule

// File: rtl/i2c_fixed_cmd_slave.sv
module i2c_fixed_cmd_slave
    import i2ccmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h34,
    parameter logic [7:0] BOOT_CODE   = 8'hF0,
    parameter logic [7:0] RESET_CODE  = 8'hBB
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic port_en,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic boot_en,
    output logic reset_req
);
    logic       core_rst;
    logic [1:0] pins_s;
    bus_evt_t   evt;
    cmd_e       fire;
    logic       bad;

    assign core_rst = rst | por;

    i2ccmd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .rst (core_rst),
        .din ({scl_i, sda_i}),
        .dout(pins_s)
    );

    i2ccmd_cond u_cond (
        .clk  (clk),
        .rst  (core_rst),
        .scl_s(pins_s[1]),
        .sda_s(pins_s[0]),
        .evt  (evt)
    );

    i2ccmd_fsm #(
        .DEV_ADDR  (DEV_ADDR),
        .BOOT_CODE (BOOT_CODE),
        .RESET_CODE(RESET_CODE)
    ) u_fsm (
        .clk    (clk),
        .rst    (core_rst),
        .port_en(port_en),
        .evt    (evt),
        .sda_oe (sda_oe),
        .fire   (fire),
        .bad    (bad)
    );

    i2ccmd_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .fire     (fire),
        .bad      (bad),
        .boot_en  (boot_en),
        .reset_req(reset_req)
    );

    // R5: an unknown command byte never drives an ACK
    p_bad_nack_r5: assert property (@(posedge clk) disable iff (core_rst)
        bad |-> !sda_oe);
endmodule

// File: tb/i2c_fixed_cmd_slave_test.sv
module i2c_fixed_cmd_slave_test;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst, por, port_en;
    logic scl_m, sda_m;
    logic sda_oe, boot_en, reset_req;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_fixed_cmd_slave uut (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .port_en  (port_en),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .boot_en  (boot_en),
        .reset_req(reset_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    int wide = 0;
    int loud = 0;
    logic req_prev = 1'b0;
    logic quiet = 1'b0;
    logic done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];
    event  ack_ev;

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (reset_req) pulses++;
        if (reset_req && req_prev) wide++;
        req_prev = reset_req;
        if (quiet && sda_oe) loud++;
    end

    // scoreboard monitor: compare ACK slot against expected queue
    initial forever begin
        @(ack_ev);
        if (exp_q.size() == 0) begin
            check(1'b0, "ack-queue-empty", 32'd1, 32'd0);
        end else begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(sda_line == e, t, 32'(sda_line), 32'(e));
        end
    end

    task automatic wait_c(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_c(HALF);
        scl_m = 1'b1; wait_c(HALF);
        sda_m = 1'b0; wait_c(HALF);
        scl_m = 1'b0; wait_c(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_c(HALF);
        scl_m = 1'b1; wait_c(HALF);
        sda_m = 1'b1; wait_c(HALF);
    endtask

    // exp_ack: 0 = ACK expected, 1 = NACK expected
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_c(HALF);
            scl_m = 1'b1; wait_c(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1;
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        wait_c(HALF);
        scl_m = 1'b1; wait_c(HALF / 2);
        ->ack_ev;
        wait_c(HALF / 2);
        scl_m = 1'b0; wait_c(4);
    endtask

    initial begin
        int p0;
        rst = 1'b1; por = 1'b1; port_en = 1'b1;
        scl_m = 1'b1; sda_m = 1'b1;
        wait_c(5);
        rst = 1'b0; por = 1'b0;
        wait_c(5);

        // R6 reset state
        check(boot_en == 1'b0, "R6 boot_en after por", 32'(boot_en), 0);
        check(reset_req == 1'b0, "R6 reset_req after reset", 32'(reset_req), 0);
        check(sda_oe == 1'b0, "R6 sda_oe after reset", 32'(sda_oe), 0);

        // R1 R9 R3: arm bootload
        bus_start();
        send_byte(8'h68, 1'b0, "R1 write header ACK");
        send_byte(8'hF0, 1'b0, "R9 F0 ACK");
        check(boot_en == 1'b0, "R3 flag before STOP", 32'(boot_en), 0);
        bus_stop();
        wait_c(10);
        check(boot_en == 1'b1, "R3 flag after STOP", 32'(boot_en), 1);

        // R6 system reset keeps the flag
        rst = 1'b1; wait_c(3); rst = 1'b0; wait_c(5);
        check(boot_en == 1'b1, "R6 flag through rst", 32'(boot_en), 1);

        // R4 R9 self reset
        p0 = pulses;
        bus_start();
        send_byte(8'h68, 1'b0, "R1 header ACK (reset cmd)");
        send_byte(8'hBB, 1'b0, "R9 BB ACK");
        check(pulses == p0, "R4 no pulse before STOP", 32'(pulses), 32'(p0));
        bus_stop();
        wait_c(10);
        check(pulses == p0 + 1, "R4 one pulse after STOP", 32'(pulses), 32'(p0 + 1));
        check(wide == 0, "R4 pulse width one cycle", 32'(wide), 0);
        check(boot_en == 1'b1, "R4 flag untouched by BB", 32'(boot_en), 1);

        // R5 unknown byte clears at once and NACKs
        bus_start();
        send_byte(8'h68, 1'b0, "R1 header ACK (bad cmd)");
        send_byte(8'h55, 1'b1, "R5 unknown byte NACK");
        check(boot_en == 1'b0, "R5 flag cleared before STOP", 32'(boot_en), 0);
        bus_stop();
        wait_c(10);
        check(boot_en == 1'b0, "R5 flag cleared after STOP", 32'(boot_en), 0);

        // re-arm for R2
        bus_start();
        send_byte(8'h68, 1'b0, "R1 header ACK (re-arm)");
        send_byte(8'hF0, 1'b0, "R9 F0 ACK (re-arm)");
        bus_stop();
        wait_c(10);

        // R2 foreign address
        p0 = pulses;
        loud = 0;
        bus_start();
        quiet = 1'b1;
        send_byte(8'h44, 1'b1, "R2 foreign address NACK");
        send_byte(8'h55, 1'b1, "R2 foreign data NACK");
        bus_stop();
        quiet = 1'b0;
        wait_c(10);
        check(boot_en == 1'b1, "R2 flag kept after foreign addr", 32'(boot_en), 1);

        // R2 read header to own address
        bus_start();
        quiet = 1'b1;
        send_byte(8'h69, 1'b1, "R2 read header NACK");
        send_byte(8'hBB, 1'b1, "R2 data after read NACK");
        bus_stop();
        quiet = 1'b0;
        wait_c(10);
        check(boot_en == 1'b1, "R2 flag kept after read", 32'(boot_en), 1);
        check(pulses == p0, "R2 no pulse after read", 32'(pulses), 32'(p0));
        check(loud == 0, "R2 SDA never driven", 32'(loud), 0);

        // R7 port disabled
        port_en = 1'b0;
        wait_c(5);
        bus_start();
        quiet = 1'b1;
        send_byte(8'h68, 1'b1, "R7 header NACK while off");
        send_byte(8'h55, 1'b1, "R7 data NACK while off");
        bus_stop();
        bus_start();
        send_byte(8'h68, 1'b1, "R7 header NACK while off (BB)");
        send_byte(8'hBB, 1'b1, "R7 BB NACK while off");
        bus_stop();
        quiet = 1'b0;
        wait_c(10);
        check(boot_en == 1'b1, "R7 flag kept while off", 32'(boot_en), 1);
        check(pulses == p0, "R7 no pulse while off", 32'(pulses), 32'(p0));
        check(loud == 0, "R7 SDA never driven while off", 32'(loud), 0);
        port_en = 1'b1;
        wait_c(5);

        // R8 repeated START drops BB
        bus_start();
        send_byte(8'h68, 1'b0, "R8 header ACK");
        send_byte(8'hBB, 1'b0, "R8 BB ACK");
        bus_start();
        send_byte(8'h44, 1'b1, "R8 foreign header NACK");
        bus_stop();
        wait_c(10);
        check(pulses == p0, "R8 BB dropped by repeated START", 32'(pulses), 32'(p0));

        // R8 repeated START drops F0
        bus_start();
        send_byte(8'h68, 1'b0, "R8 header ACK (clear)");
        send_byte(8'h3C, 1'b1, "R5 unknown byte NACK (clear)");
        bus_stop();
        wait_c(10);
        bus_start();
        send_byte(8'h68, 1'b0, "R8 header ACK (F0)");
        send_byte(8'hF0, 1'b0, "R8 F0 ACK");
        bus_start();
        send_byte(8'h44, 1'b1, "R8 foreign header NACK (F0)");
        bus_stop();
        wait_c(10);
        check(boot_en == 1'b0, "R8 F0 dropped by repeated START", 32'(boot_en), 0);

        // R6 power-on reset clears the flag
        bus_start();
        send_byte(8'h68, 1'b0, "R1 header ACK (por)");
        send_byte(8'hF0, 1'b0, "R9 F0 ACK (por)");
        bus_stop();
        wait_c(10);
        check(boot_en == 1'b1, "R3 flag set before por", 32'(boot_en), 1);
        por = 1'b1; wait_c(3); por = 1'b0; wait_c(5);
        check(boot_en == 1'b0, "R6 flag cleared by por", 32'(boot_en), 0);

        check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule